// File: doc/BRIEF.md
# Stop-Recovery Delay and Configuration Controller

This block keeps the small configuration word of a microcontroller and controls how the part leaves its low-power stop state. The configuration word holds four bits: a short-recovery select, a stop enable, a watchdog disable and a supply-mode select for the low-voltage detector. After any reset the word accepts one write. When the CPU executes a stop opcode, the block either parks the part in stop or reports the opcode as illegal. A later wake event starts a recovery count, and the CPU clock stays held until that count ends.

A single counter sets every delay the block produces: the short and long stop recovery, and the stabilisation period after power-on and low-voltage resets. A reset that arrives in the middle of a count abandons it and starts again with the delay that belongs to that reset source. The analog detector, the watchdog and the CPU are outside the block and appear only as signals.

Top module: `stop_wake_cfg`

## Requirements
- R1: Configuration bit positions are: bit 0 short recovery, bit 1 stop enable, bit 2 watchdog disable, bit 3 5 V mode. Any reset clears bits 0 to 2, which gives long recovery, stop disabled and the watchdog enabled.
- R2: After a reset, only the first `cfg_we` cycle loads the word. Every later write leaves all four outputs and behaviours unchanged until the next reset. Writes made while a reset is active are ignored.
- R3: With short recovery set, `rec_done_o` rises exactly 32 clock edges after the edge that samples `wake` in stop.
- R4: With short recovery clear, `rec_done_o` rises exactly 4096 clock edges after the wake edge.
- R5: A low-voltage reset, whether it arrives in stop or during a recovery count, aborts the count. It is followed by a 4096-edge delay counted from the last edge on which the reset is active, whatever the short-recovery bit held.
- R6: Power-on reset clears the 5 V mode bit and is followed by a 4096-edge stabilisation delay that ends in a `rec_done_o` pulse.
- R7: The 5 V mode bit (1 = 5 V, 0 = 3 V) keeps its value through low-voltage and other resets.
- R8: An other-source reset clears `stopped_o` and does not start a count, so no `rec_done_o` pulse follows it.
- R9: When stop is enabled, a stop opcode sets `stopped_o`. When stop is disabled, the opcode gives a one-cycle `illegal_o` pulse and `stopped_o` stays low.
- R10: `wdog_en_o` is the inverse of the watchdog-disable bit.
- R11: `rec_done_o` lasts exactly one cycle, and `stopped_o` falls on the same edge. A wake is ignored outside stop, and a stop opcode is ignored while the clock is held.
- R12: When a reset and a wake are sampled on the same edge, the reset wins. The count that follows is the one for that reset source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast recovery clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| lvr_i | input | 1 | Low-voltage reset, active high, synchronous |
| rst_i | input | 1 | Any other reset source, active high, synchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| op_stop | input | 1 | Stop opcode decoded and executed |
| wake | input | 1 | Wake event from stop |
| stopped_o | output | 1 | High while the CPU clock is held (stop or recovery) |
| rec_done_o | output | 1 | One-cycle pulse that releases the CPU clock |
| illegal_o | output | 1 | One-cycle illegal-opcode strobe |
| wdog_en_o | output | 1 | Watchdog enable |
| volt_5v_o | output | 1 | Detector supply mode, 1 = 5 V |

## Verification
Two events can land on the same edge: a wake that would start a short recovery and a low-voltage reset. The bench enables short recovery, enters stop, and then raises `wake` and `lvr_i` together for one edge. The result is correct only if `rec_done_o` comes 4096 edges later instead of 32, and the 5 V mode bit is unchanged. A second collision puts a stop opcode in the middle of a running count; the bench expects no illegal strobe and an unchanged delay.

// File: rtl/stop_wake_cfg.sv
`timescale 1ns/1ps
module stop_wake_cfg #(
  parameter int SHORT_CYC = 32,
  parameter int LONG_CYC  = 4096
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       lvr_i,
  input  logic       rst_i,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       op_stop,
  input  logic       wake,
  output logic       stopped_o,
  output logic       rec_done_o,
  output logic       illegal_o,
  output logic       wdog_en_o,
  output logic       volt_5v_o
);
  localparam int CW = $clog2(LONG_CYC);
  typedef enum logic [1:0] {RUN, HALT, RECOV} phase_t;

  phase_t  phase;
  logic [CW-1:0] cnt;
  logic    use_long, short_q, stopen_q, wdoff_q, v5_q, written;
  logic    any_rst, load;
  logic [CW-1:0] last;

  assign any_rst = por_i | lvr_i | rst_i;
  assign load    = cfg_we & ~written & ~any_rst;
  assign last    = use_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

  always_ff @(posedge clk) begin
    if (por_i)     v5_q <= 1'b0;
    else if (load) v5_q <= cfg_wdata[3];
    if (any_rst) begin
      {wdoff_q, stopen_q, short_q} <= 3'b000;
      written <= 1'b0;
    end else if (load) begin
      {wdoff_q, stopen_q, short_q} <= cfg_wdata[2:0];
      written <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    rec_done_o <= 1'b0;
    illegal_o  <= 1'b0;
    if (any_rst) begin
      phase    <= (por_i | lvr_i) ? RECOV : RUN;
      cnt      <= '0;
      use_long <= 1'b1;
    end else begin
      case (phase)
        RUN:  if (op_stop) begin
                if (stopen_q) phase <= HALT;
                else illegal_o <= 1'b1;
              end
        HALT: if (wake) begin
                phase    <= RECOV;
                cnt      <= '0;
                use_long <= ~short_q;
              end
        RECOV: if (cnt == last) begin
                 rec_done_o <= 1'b1;
                 phase      <= RUN;
                 cnt        <= '0;
               end else cnt <= cnt + 1'b1;
        default: phase <= RUN;
      endcase
    end
  end

  assign stopped_o = (phase != RUN);
  assign wdog_en_o = ~wdoff_q;
  assign volt_5v_o = v5_q;

  assert_pulse_R11: assert property (@(posedge clk) disable iff (any_rst)
    rec_done_o |=> !rec_done_o);
  assert_release_R11: assert property (@(posedge clk) disable iff (any_rst)
    rec_done_o |-> !stopped_o);
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (any_rst)
    (phase == RECOV) |-> (cnt <= last));
  assert_enter_R9: assert property (@(posedge clk) disable iff (any_rst)
    ($rose(stopped_o) && !$past(any_rst)) |-> $past(op_stop && stopen_q));
  assert_illegal_R9: assert property (@(posedge clk) disable iff (any_rst)
    illegal_o |-> (!stopped_o && $past(!stopen_q)));
  assert_volt_keep_R7: assert property (@(posedge clk) disable iff (por_i)
    (lvr_i || rst_i) |=> $stable(volt_5v_o));
  assert_write_once_R2: assert property (@(posedge clk) disable iff (any_rst)
    written |=> $stable({short_q, stopen_q, wdoff_q, v5_q}));
endmodule

// File: tb/sim_stop_wake_cfg.sv
`timescale 1ns/1ps
module sim_stop_wake_cfg;
  logic clk = 0, por_i = 0, lvr_i = 0, rst_i = 0, cfg_we = 0, op_stop = 0, wake = 0;
  logic [3:0] cfg_wdata = '0;
  logic stopped_o, rec_done_o, illegal_o, wdog_en_o, volt_5v_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stop_wake_cfg u0 (.clk, .por_i, .lvr_i, .rst_i, .cfg_we, .cfg_wdata, .op_stop,
    .wake, .stopped_o, .rec_done_o, .illegal_o, .wdog_en_o, .volt_5v_o);

  // {wdata[3:0], exp wdog_en, exp stop accepted, exp delay[13:0]}
  localparam logic [19:0] VEC [7] = '{
    {4'b0011, 1'b1, 1'b1, 14'd32},   {4'b0010, 1'b1, 1'b1, 14'd4096},
    {4'b0110, 1'b0, 1'b1, 14'd4096}, {4'b0111, 1'b0, 1'b1, 14'd32},
    {4'b0001, 1'b1, 1'b0, 14'd0},    {4'b1101, 1'b0, 1'b0, 14'd0},
    {4'b1011, 1'b1, 1'b1, 14'd32}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rec_done_o && n < 5000);
  endtask

  task automatic pulse_reset(input int kind);
    @(negedge clk);
    if (kind == 0) por_i = 1; else if (kind == 1) lvr_i = 1; else rst_i = 1;
    @(negedge clk); @(negedge clk);
    por_i = 0; lvr_i = 0; rst_i = 0;
  endtask

  task automatic write_cfg(input logic [3:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); op_stop = 1;
    @(negedge clk); op_stop = 0;
  endtask

  task automatic do_wake();
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
  endtask

  initial begin
    int n;
    logic v5_prev;
    @(negedge clk); por_i = 1;
    @(negedge clk);
    chk(volt_5v_o == 0 && wdog_en_o == 1 && stopped_o == 1 && rec_done_o == 0,
        "R1 R6 reset state", {volt_5v_o, wdog_en_o, stopped_o}, 3'b011);
    @(negedge clk); por_i = 0;
    measure(n);
    chk(n == 4096, "R6 power-on stabilisation", n, 4096);

    for (int i = 0; i < 7; i++) begin
      logic [3:0] w;
      w = VEC[i][19:16];
      v5_prev = volt_5v_o;
      pulse_reset(2);
      repeat (3) @(negedge clk);
      chk(!stopped_o && !rec_done_o, "R8 other reset no count", stopped_o, 0);
      chk(wdog_en_o == 1, "R1 default watchdog on", wdog_en_o, 1);
      chk(volt_5v_o == v5_prev, "R7 mode kept over other reset", volt_5v_o, v5_prev);
      write_cfg(w);
      chk(wdog_en_o == VEC[i][15], "R10 watchdog enable", wdog_en_o, VEC[i][15]);
      chk(volt_5v_o == w[3], "R1 mode bit", volt_5v_o, w[3]);
      write_cfg(~w);
      chk(wdog_en_o == VEC[i][15] && volt_5v_o == w[3], "R2 second write ignored",
          {wdog_en_o, volt_5v_o}, {VEC[i][15], w[3]});
      do_stop();
      chk(stopped_o == VEC[i][14], "R9 stop entry", stopped_o, VEC[i][14]);
      chk(illegal_o == !VEC[i][14], "R9 illegal strobe", illegal_o, !VEC[i][14]);
      @(negedge clk);
      chk(!illegal_o, "R9 illegal one cycle", illegal_o, 0);
      if (VEC[i][14]) begin
        do_wake();
        measure(n);
        chk(n == int'(VEC[i][13:0]), w[0] ? "R3 short recovery" : "R4 long recovery",
            n, VEC[i][13:0]);
        chk(!stopped_o, "R11 stopped clears with done", stopped_o, 0);
        @(negedge clk);
        chk(!rec_done_o, "R11 done one cycle", rec_done_o, 1'b0);
      end else begin
        do_wake();
        repeat (40) begin
          @(negedge clk);
          if (stopped_o || rec_done_o) break;
        end
        chk(!stopped_o && !rec_done_o, "R11 wake ignored outside stop", rec_done_o, 0);
      end
    end

    // volt is 1 here; low-voltage reset keeps it and forces long delay
    pulse_reset(1);
    measure(n);
    chk(n == 4096 && volt_5v_o == 1, "R5 R7 low-voltage reset", n, 4096);

    // low-voltage reset during a short recovery
    write_cfg(4'b0011); do_stop(); do_wake();
    repeat (10) @(negedge clk);
    chk(!rec_done_o && stopped_o, "R3 count running", stopped_o, 1);
    pulse_reset(1);
    measure(n);
    chk(n == 4096, "R5 reset aborts short count", n, 4096);

    // wake and low-voltage reset on the same edge
    write_cfg(4'b0011); do_stop();
    @(negedge clk); wake = 1; lvr_i = 1;
    @(negedge clk); wake = 0; lvr_i = 0;
    measure(n);
    chk(n == 4096, "R12 reset beats wake", n, 4096);
    chk(volt_5v_o == 0, "R12 mode untouched", volt_5v_o, 0);

    // stop opcode during a running count is ignored
    write_cfg(4'b0011); do_stop(); do_wake();
    repeat (5) @(negedge clk);
    op_stop = 1; @(negedge clk); op_stop = 0;
    chk(!illegal_o, "R11 opcode ignored while held", illegal_o, 0);
    n = 6;
    do begin @(negedge clk); n++; end while (!rec_done_o && n < 100);
    chk(n == 32, "R11 delay unchanged by opcode", n, 32);
    @(negedge clk);
    chk(!stopped_o, "R11 no re-entry", stopped_o, 0);

    // power-on clears the mode bit
    pulse_reset(2);
    write_cfg(4'b1000);
    chk(volt_5v_o == 1, "R1 mode set", volt_5v_o, 1);
    pulse_reset(0);
    chk(volt_5v_o == 0, "R6 power-on clears mode", volt_5v_o, 0);
    measure(n);
    chk(n == 4096, "R6 stabilisation repeat", n, 4096);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule